// File: doc/BRIEF.md
# Test access port controller

This block is the sixteen-state sequencer that sits behind a serial test port. It runs on the test clock and samples the mode-select input on every rising edge. That one input alone steers the controller through the data-register and instruction-register scan sequences. The registers the scan chain reaches are outside this block. It only tells them when to capture, shift and update.

Capture and shift enables are decoded straight from the current state, so a register that sees one of them acts on the rising edge that ends that state. The two update strobes and the serial-output driver enable are retimed to the falling edge, so that parallel outputs and the serial pin change half a cycle away from the sampling edge. A reset-state flag tells the rest of the test logic to stand aside. An active-low reset input returns the controller to the reset state. By default this reset acts at once, without a clock edge; a parameter selects a clocked variant instead.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `trst_n` is low the controller is in the reset state (code 0), with `tlr_o` high and every other strobe and `tdo_en_o` low. With the default asynchronous reset this takes effect immediately, without waiting for any clock edge.
- R2: State codes on `state_o`: reset 0, idle 1, select-data 2, capture-data 3, shift-data 4, exit1-data 5, pause-data 6, exit2-data 7, update-data 8, select-instr 9, capture-instr 10, shift-instr 11, exit1-instr 12, pause-instr 13, exit2-instr 14, update-instr 15. On each rising `tck` edge the state moves as follows (mode-select low / high). Reset goes to idle / reset. Idle goes to idle / select-data. Select-data goes to capture-data / select-instr. Capture goes to shift / exit1. Shift goes to shift / exit1. Exit1 goes to pause / update. Pause goes to pause / exit2. Exit2 goes to shift / update. Both update states go to idle / select-data. Select-instr goes to capture-instr / reset. The instruction side follows the same pattern as the data side.
- R3: Five consecutive rising edges with `tms` high reach the reset state from any state, and the controller stays there while `tms` stays high.
- R4: In idle with `tms` low the state does not change, and no update strobe fires.
- R5: `cap_dr_o`, `shf_dr_o`, `cap_ir_o` and `shf_ir_o` are each high exactly while the controller is in the matching capture or shift state. They change just after the rising edge.
- R6: `upd_dr_o` and `upd_ir_o` rise on the falling `tck` edge inside the matching update state and fall on the first falling edge after it.
- R7: `tdo_en_o` is high only from the falling edge inside a shift state (data or instruction) until the next falling edge outside one. It is low at all other times.
- R8: In exit1, pause and exit2 (both sides) no capture, shift or update strobe is active, so the selected registers hold.
- R9: `tlr_o` is high exactly while the state is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| state_o | output | 4 | Current state code (R2) |
| tlr_o | output | 1 | Controller is in the reset state |
| cap_dr_o | output | 1 | Capture enable for the selected data register |
| shf_dr_o | output | 1 | Shift enable for the selected data register |
| upd_dr_o | output | 1 | Data update strobe, falling-edge timed |
| cap_ir_o | output | 1 | Capture enable for the instruction register |
| shf_ir_o | output | 1 | Shift enable for the instruction register |
| upd_ir_o | output | 1 | Instruction update strobe, falling-edge timed |
| tdo_en_o | output | 1 | Serial output driver enable, falling-edge timed |

## Verification
A wrong next-state entry shows on `state_o` at the rising edge where it is taken. The strobes decoded from that state follow with no delay. The falling-edge strobes follow half a cycle later, so a stray update or output enable is visible within one test-clock period. A controller that never recovers from a bad state would leave `tlr_o` low after five edges with mode-select high. For that reason the reset walk is repeated from every state the vector table reaches. A reset that waits for a clock edge shows as a nonzero `state_o` sampled between edges while `trst_n` is low.

// File: rtl/scan_tap_pkg.sv
// Package: shared state type for the test access port controller.
// Assumes a 4-bit state code; the name function serves benches and logs.
package scan_tap_pkg;

    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SHF_DR = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SHF_IR = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_st_e;

    // Maps a state code to a readable name for checking and messages.
    function automatic string tap_st_name(input tap_st_e s);
        case (s)
            ST_RESET:  return "RESET";
            ST_IDLE:   return "IDLE";
            ST_SEL_DR: return "SEL_DR";
            ST_CAP_DR: return "CAP_DR";
            ST_SHF_DR: return "SHF_DR";
            ST_EX1_DR: return "EX1_DR";
            ST_PAU_DR: return "PAU_DR";
            ST_EX2_DR: return "EX2_DR";
            ST_UPD_DR: return "UPD_DR";
            ST_SEL_IR: return "SEL_IR";
            ST_CAP_IR: return "CAP_IR";
            ST_SHF_IR: return "SHF_IR";
            ST_EX1_IR: return "EX1_IR";
            ST_PAU_IR: return "PAU_IR";
            ST_EX2_IR: return "EX2_IR";
            default:   return "UPD_IR";
        endcase
    endfunction

endpackage

// File: rtl/scan_tap_next.sv
// Module: next-state function of the controller.
// Purely combinational; assumes the mode-select input is already stable
// for the coming rising edge.
module scan_tap_next
    import scan_tap_pkg::*;
(
    input  tap_st_e cur_i,
    input  logic    tms_i,
    output tap_st_e nxt_o
);

    // Selects the successor state from the current state and mode-select.
    always_comb begin
        nxt_o = ST_RESET;
        case (cur_i)
            ST_RESET:  nxt_o = tms_i ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt_o = tms_i ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt_o = tms_i ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt_o = tms_i ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt_o = tms_i ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt_o = tms_i ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt_o = tms_i ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt_o = tms_i ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt_o = tms_i ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt_o = tms_i ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt_o = tms_i ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt_o = tms_i ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt_o = tms_i ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
            default:   nxt_o = ST_RESET;
        endcase
    end

endmodule

// File: rtl/scan_tap_state.sv
// Module: state register of the controller.
// ASYNC_RST=1 makes the active-low reset act without a clock edge;
// ASYNC_RST=0 samples it on the rising test-clock edge.
module scan_tap_state
    import scan_tap_pkg::*;
#(
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms_i,
    input  tap_st_e nxt_i,
    output tap_st_e cur_o
);

    localparam int ONES_TO_RESET = 5;
    localparam int ONES_W        = $clog2(ONES_TO_RESET + 1);

    tap_st_e st_q;

    generate
        if (ASYNC_RST) begin : gen_async
            // Holds the current state; reset forces it at once.
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) st_q <= ST_RESET;
                else         st_q <= nxt_i;
            end
        end else begin : gen_sync
            // Holds the current state; reset is taken on the rising edge.
            always_ff @(posedge tck) begin
                if (!trst_n) st_q <= ST_RESET;
                else         st_q <= nxt_i;
            end
        end
    endgenerate

    assign cur_o = st_q;

    // Counts consecutive high mode-select samples, saturating, for the check below.
    logic [ONES_W-1:0] ones_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                                    ones_q <= '0;
        else if (!tms_i)                                ones_q <= '0;
        else if (ones_q != ONES_W'(ONES_TO_RESET))      ones_q <= ones_q + 1'b1;
    end

    // R3
    five_ones_reach_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == ONES_W'(ONES_TO_RESET)) |-> (st_q == ST_RESET));

    // R3
    reset_sticks_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_RESET && tms_i) |=> (st_q == ST_RESET));

    // R4
    idle_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_IDLE && !tms_i) |=> (st_q == ST_IDLE));

    // R2
    capture_follows_select_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st_q == ST_SEL_DR && !tms_i) |=> (st_q == ST_CAP_DR));

endmodule

// File: rtl/scan_tap_strobe.sv
// Module: strobe decode for the controller.
// Capture/shift enables and the reset flag are decoded from the state and
// used by registers at the next rising edge; update strobes and the output
// driver enable are retimed to the falling edge.
module scan_tap_strobe
    import scan_tap_pkg::*;
#(
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic    tck,
    input  logic    trst_n,
    input  tap_st_e cur_i,
    output logic    tlr_o,
    output logic    cap_dr_o,
    output logic    shf_dr_o,
    output logic    upd_dr_o,
    output logic    cap_ir_o,
    output logic    shf_ir_o,
    output logic    upd_ir_o,
    output logic    tdo_en_o
);

    localparam int FALL_W = 3;

    logic [FALL_W-1:0] fall_d;
    logic [FALL_W-1:0] fall_q;

    // Decodes the rising-edge enables straight from the state.
    always_comb begin
        tlr_o    = (cur_i == ST_RESET);
        cap_dr_o = (cur_i == ST_CAP_DR);
        shf_dr_o = (cur_i == ST_SHF_DR);
        cap_ir_o = (cur_i == ST_CAP_IR);
        shf_ir_o = (cur_i == ST_SHF_IR);
    end

    // Forms the next values of the falling-edge strobes.
    always_comb begin
        fall_d[0] = (cur_i == ST_UPD_DR);
        fall_d[1] = (cur_i == ST_UPD_IR);
        fall_d[2] = (cur_i == ST_SHF_DR) || (cur_i == ST_SHF_IR);
    end

    generate
        if (ASYNC_RST) begin : gen_async
            // Retimes update and driver-enable strobes to the falling edge.
            always_ff @(negedge tck or negedge trst_n) begin
                if (!trst_n) fall_q <= '0;
                else         fall_q <= fall_d;
            end
        end else begin : gen_sync
            // Retimes update and driver-enable strobes to the falling edge.
            always_ff @(negedge tck) begin
                if (!trst_n) fall_q <= '0;
                else         fall_q <= fall_d;
            end
        end
    endgenerate

    assign upd_dr_o = fall_q[0];
    assign upd_ir_o = fall_q[1];
    assign tdo_en_o = fall_q[2];

    // R5
    rise_strobes_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({tlr_o, cap_dr_o, shf_dr_o, cap_ir_o, shf_ir_o}));

    // R6
    upd_dr_in_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
        upd_dr_o |-> (cur_i == ST_UPD_DR));

    // R6
    upd_ir_in_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
        upd_ir_o |-> (cur_i == ST_UPD_IR));

    // R7
    tdo_en_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en_o |-> (cur_i == ST_SHF_DR || cur_i == ST_SHF_IR));

    // R8
    hold_states_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (cur_i == ST_PAU_DR || cur_i == ST_PAU_IR) |=> !(upd_dr_o || upd_ir_o));

endmodule

// File: rtl/scan_tap_ctrl.sv
// Module: top of the test access port controller.
// Wires next-state logic, state register and strobe decode; the controlled
// registers and instruction decode live outside.
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    output logic [ST_W-1:0] state_o,
    output logic            tlr_o,
    output logic            cap_dr_o,
    output logic            shf_dr_o,
    output logic            upd_dr_o,
    output logic            cap_ir_o,
    output logic            shf_ir_o,
    output logic            upd_ir_o,
    output logic            tdo_en_o
);

    tap_st_e cur_st;
    tap_st_e nxt_st;

    scan_tap_next u_next (
        .cur_i (cur_st),
        .tms_i (tms),
        .nxt_o (nxt_st)
    );

    scan_tap_state #(.ASYNC_RST(ASYNC_RST)) u_state (
        .tck    (tck),
        .trst_n (trst_n),
        .tms_i  (tms),
        .nxt_i  (nxt_st),
        .cur_o  (cur_st)
    );

    scan_tap_strobe #(.ASYNC_RST(ASYNC_RST)) u_strobe (
        .tck      (tck),
        .trst_n   (trst_n),
        .cur_i    (cur_st),
        .tlr_o    (tlr_o),
        .cap_dr_o (cap_dr_o),
        .shf_dr_o (shf_dr_o),
        .upd_dr_o (upd_dr_o),
        .cap_ir_o (cap_ir_o),
        .shf_ir_o (shf_ir_o),
        .upd_ir_o (upd_ir_o),
        .tdo_en_o (tdo_en_o)
    );

    assign state_o = cur_st;

endmodule

// File: tb/scan_tap_ctrl_bench.sv
// Bench: walks a vector table of mode-select values and expected states,
// then directed checks for the five-ones recovery and the immediate reset.
module scan_tap_ctrl_bench;
    import scan_tap_pkg::*;

    localparam int NV = 44;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic [3:0] state_o;
    logic       tlr_o, cap_dr_o, shf_dr_o, upd_dr_o;
    logic       cap_ir_o, shf_ir_o, upd_ir_o, tdo_en_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 tck = ~tck;

    scan_tap_ctrl u_scan_tap_ctrl (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
        .tlr_o(tlr_o), .cap_dr_o(cap_dr_o), .shf_dr_o(shf_dr_o),
        .upd_dr_o(upd_dr_o), .cap_ir_o(cap_ir_o), .shf_ir_o(shf_ir_o),
        .upd_ir_o(upd_ir_o), .tdo_en_o(tdo_en_o)
    );

    // Each entry: {tms, expected state after the rising edge}.
    localparam logic [4:0] VEC [NV] = '{
        {1'b0, ST_IDLE},   {1'b0, ST_IDLE},   {1'b1, ST_SEL_DR}, {1'b0, ST_CAP_DR},
        {1'b0, ST_SHF_DR}, {1'b0, ST_SHF_DR}, {1'b1, ST_EX1_DR}, {1'b0, ST_PAU_DR},
        {1'b0, ST_PAU_DR}, {1'b1, ST_EX2_DR}, {1'b0, ST_SHF_DR}, {1'b1, ST_EX1_DR},
        {1'b1, ST_UPD_DR}, {1'b1, ST_SEL_DR}, {1'b1, ST_SEL_IR}, {1'b0, ST_CAP_IR},
        {1'b1, ST_EX1_IR}, {1'b0, ST_PAU_IR}, {1'b1, ST_EX2_IR}, {1'b0, ST_SHF_IR},
        {1'b1, ST_EX1_IR}, {1'b1, ST_UPD_IR}, {1'b0, ST_IDLE},   {1'b1, ST_SEL_DR},
        {1'b0, ST_CAP_DR}, {1'b1, ST_EX1_DR}, {1'b0, ST_PAU_DR}, {1'b1, ST_EX2_DR},
        {1'b1, ST_UPD_DR}, {1'b0, ST_IDLE},   {1'b1, ST_SEL_DR}, {1'b1, ST_SEL_IR},
        {1'b0, ST_CAP_IR}, {1'b0, ST_SHF_IR}, {1'b0, ST_SHF_IR}, {1'b1, ST_EX1_IR},
        {1'b0, ST_PAU_IR}, {1'b1, ST_EX2_IR}, {1'b1, ST_UPD_IR}, {1'b1, ST_SEL_DR},
        {1'b1, ST_SEL_IR}, {1'b1, ST_RESET},  {1'b1, ST_RESET},  {1'b0, ST_IDLE}
    };

    // Records one comparison and reports it on mismatch.
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Applies one mode-select value and checks both edges against the expected state.
    task automatic step(input logic t, input tap_st_e exp, input bit full);
        tms = t;
        @(posedge tck);
        #2;
        chk("R2 state", {4'h0, state_o}, {4'h0, exp});
        if (full) begin
            chk((exp inside {ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR})
                    ? "R8 rise strobes" : "R5 rise strobes",
                {4'h0, cap_dr_o, shf_dr_o, cap_ir_o, shf_ir_o},
                {4'h0, exp == ST_CAP_DR, exp == ST_SHF_DR, exp == ST_CAP_IR, exp == ST_SHF_IR});
            chk("R9 tlr", {7'h0, tlr_o}, {7'h0, exp == ST_RESET});
        end
        @(negedge tck);
        #2;
        if (full) begin
            chk("R6 update strobes", {6'h0, upd_dr_o, upd_ir_o},
                {6'h0, exp == ST_UPD_DR, exp == ST_UPD_IR});
            chk("R7 tdo_en", {7'h0, tdo_en_o}, {7'h0, exp == ST_SHF_DR || exp == ST_SHF_IR});
        end
    endtask

    // Applies reset away from any edge, checks it, and releases it.
    task automatic do_reset(input bit check);
        trst_n = 1'b0;
        #1;
        if (check) begin
            chk("R1 state", {4'h0, state_o}, {4'h0, ST_RESET});
            chk("R1 strobes", {tlr_o, cap_dr_o, shf_dr_o, upd_dr_o, cap_ir_o, shf_ir_o,
                               upd_ir_o, tdo_en_o}, 8'b1000_0000);
        end
        @(negedge tck);
        #2;
        trst_n = 1'b1;
    endtask

    initial begin
        #23;
        do_reset(1'b1);
        // Vector table walk from the reset state.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][4], tap_st_e'(VEC[i][3:0]), 1'b1);
        end
        // R4: idle held over many low samples with no update strobe.
        for (int i = 0; i < 6; i++) step(1'b0, ST_IDLE, 1'b1);
        // R3: five high samples from every state the table reaches.
        for (int p = 0; p <= NV; p++) begin
            do_reset(1'b0);
            for (int i = 0; i < p; i++) step(VEC[i][4], tap_st_e'(VEC[i][3:0]), 1'b0);
            for (int k = 0; k < 4; k++) begin
                tms = 1'b1;
                @(posedge tck);
                @(negedge tck);
                #2;
            end
            step(1'b1, ST_RESET, 1'b0);
            step(1'b1, ST_RESET, 1'b1);
        end
        // R1: reset mid-shift clears the driver enable without a clock edge.
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) step(VEC[i][4], tap_st_e'(VEC[i][3:0]), 1'b0);
        chk("R7 tdo_en before reset", {7'h0, tdo_en_o}, 8'h01);
        do_reset(1'b1);
        // R1: reset in the instruction update state clears the update strobe at once.
        for (int i = 0; i < 22; i++) step(VEC[i][4], tap_st_e'(VEC[i][3:0]), 1'b0);
        chk("R6 upd_ir before reset", {7'h0, upd_ir_o}, 8'h01);
        do_reset(1'b1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Ends a hung run as a failure.
    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule